// File: doc/BRIEF.md
# Converter Sample Capture with Over-Range Detection

This block takes in the 16-bit parallel word from a pipelined analog-to-digital converter. It registers each word on the rising edge of the converter clock and presents it twice: in its native offset-binary form and as two's complement. It flags samples that lie in the clipping windows at either end of the code range.

A small state machine decides which captured samples are valid. Samples are suppressed while the converter's output enable is low. For a fixed run of samples after the enable rises, or after the gain changes, samples are also suppressed, because the converter pipeline still holds data taken under the old conditions.

The block also holds the 3-bit gain code that drives the front-end amplifier, and it refuses the one forbidden code. Two results are kept as status:
- a saturating count of valid clipped samples;
- a sticky flag that is set whenever the converter's own over-range pin disagrees with the flag computed from the code.

State machine (`cap_state_e`):
- `ST_OFF`: output enable is low; no sample is valid.
- `ST_SETTLE`: counting down the blanking window.
- `ST_LIVE`: samples are valid.

Transitions:
- *enable-seen*: `ST_OFF` to `ST_SETTLE`.
- *window-done*: `ST_SETTLE` to `ST_LIVE`, when the countdown reaches zero.
- *gain-retune*: `ST_LIVE` or `ST_SETTLE` to `ST_SETTLE`, restarting the countdown, when a legal gain write changes the code.
- *disable*: any state to `ST_OFF`, whenever output enable is low.

Top module: `adc_capture`

## Requirements
- R1: After reset, `smp_valid`, `smp_ovr`, `ovr_count`, `ovr_mismatch`, `illegal_gain` and `smp_tc` are 0, `smp_offs` is 16'h8000 (mid-scale) and `gain_code` is 3'b000.
- R2: The word on `adc_data` (bit 0 the LSB, bit 15 the MSB, offset binary) at a rising clock edge appears on `smp_offs` right after that edge.
- R3: `smp_tc` carries the same sample in two's complement, which is `smp_offs` with bit 15 inverted.
- R4: `smp_ovr` is 1 exactly when the captured word is at or above 16'hFC00 or at or below 16'h03FF. For example, FBFF and 0400 give 0.
- R5: `smp_valid` is 0 for every sample captured while `out_en` is low. Once `out_en` is first seen high, the first 6 captured samples are invalid and the 7th is valid.
- R6: A write (`gain_wr`) of a code from 000 to 110 that differs from `gain_code` updates `gain_code` after that edge and makes that sample and the next 5 invalid. A write of the current code leaves `smp_valid` unaffected.
- R7: A write of code 111 leaves `gain_code` unchanged and does not blank samples. It sets the sticky `illegal_gain`, which `err_clr` clears; if a set and a clear fall in the same cycle, the set wins.
- R8: `ovr_count` (CNT_W bits, default 32) increments by one for each valid sample with `smp_ovr` 1. It saturates at all ones, ignores invalid samples and is cleared only by reset.
- R9: `ovr_mismatch` becomes 1 when a valid sample's computed over-range flag differs from `adc_ovr_pin` sampled at the same edge. Invalid samples are ignored. It stays 1 until `err_clr`, and a set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; capture on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_data | input | 16 | Offset-binary sample word from the converter |
| adc_ovr_pin | input | 1 | Converter's own over-range output |
| out_en | input | 1 | Converter output enable as driven to the device |
| gain_wr | input | 1 | Gain write strobe |
| gain_wdata | input | 3 | Requested gain code |
| err_clr | input | 1 | Clears `illegal_gain` and `ovr_mismatch` |
| gain_code | output | 3 | Gain code applied to the amplifier |
| smp_valid | output | 1 | Captured sample is usable |
| smp_offs | output | 16 | Captured sample, offset binary |
| smp_tc | output | 16 | Captured sample, two's complement |
| smp_ovr | output | 1 | Captured sample lies in a clipping window |
| ovr_count | output | CNT_W | Saturating count of valid clipped samples |
| ovr_mismatch | output | 1 | Sticky: computed and pin over-range disagreed |
| illegal_gain | output | 1 | Sticky: forbidden gain code was written |

## Verification
The assertions check, on every cycle:
- that the clip flag agrees with the captured word, and that the two's-complement form agrees with the offset form;
- that the gain code never takes the forbidden value and holds across a forbidden write;
- that both sticky flags hold until cleared, and that the clip counter never goes down;
- that a valid sample never follows a low enable, and that the first sample after an enable rise or a gain change is invalid.

Only the bench scenarios can show the rest:
- the exact length of the six-sample blanking window;
- that a rewrite of the same code leaves the stream alone;
- the exact clip window edges;
- counter saturation;
- that invalid samples affect neither the counter nor the mismatch flag.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LIVE   = 2'd2
    } cap_state_e;

endpackage

// File: rtl/adc_gain_ctrl.sv
module adc_gain_ctrl #(
    parameter int GAIN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [GAIN_W-1:0] wdata,
    input  logic              err_clr,
    output logic [GAIN_W-1:0] gain_code,
    output logic              illegal,
    output logic              changed
);
    localparam logic [GAIN_W-1:0] FORBIDDEN = {GAIN_W{1'b1}};

    logic bad_wr;

    always_comb begin
        bad_wr  = wr && (wdata == FORBIDDEN);
        changed = wr && (wdata != FORBIDDEN) && (wdata != gain_code);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_code <= '0;
            illegal   <= 1'b0;
        end else begin
            if (changed) gain_code <= wdata;
            if (bad_wr)       illegal <= 1'b1;
            else if (err_clr) illegal <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_settle_fsm.sv
module adc_settle_fsm
    import adc_cap_pkg::*;
#(
    parameter int BLANK = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    input  logic gain_chg,
    output logic live_nxt
);
    localparam int CW = $clog2(BLANK + 1);
    localparam logic [CW-1:0] RELOAD = CW'(BLANK - 1);

    cap_state_e    st, st_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            ST_OFF: begin
                if (out_en) begin
                    st_nxt  = ST_SETTLE;
                    cnt_nxt = RELOAD;
                end
            end
            ST_SETTLE: begin
                if (!out_en) begin
                    st_nxt = ST_OFF;
                end else if (gain_chg) begin
                    cnt_nxt = RELOAD;
                end else if (cnt == '0) begin
                    st_nxt = ST_LIVE;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_LIVE: begin
                if (!out_en) begin
                    st_nxt = ST_OFF;
                end else if (gain_chg) begin
                    st_nxt  = ST_SETTLE;
                    cnt_nxt = RELOAD;
                end
            end
            default: st_nxt = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        live_nxt = (st_nxt == ST_LIVE);
    end
endmodule

// File: rtl/adc_ovr_stat.sv
module adc_ovr_stat #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             calc_ovr,
    input  logic             pin_ovr,
    input  logic             err_clr,
    output logic [CNT_W-1:0] count,
    output logic             mismatch
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            mismatch <= 1'b0;
        end else begin
            if (take && calc_ovr && (count != SAT)) count <= count + 1'b1;
            if (take && (calc_ovr != pin_ovr)) mismatch <= 1'b1;
            else if (err_clr)                  mismatch <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
    parameter int                 DATA_W  = 16,
    parameter int                 GAIN_W  = 3,
    parameter int                 CNT_W   = 32,
    parameter int                 BLANK   = 6,
    parameter logic [DATA_W-1:0]  CLIP_HI = 16'hFC00,
    parameter logic [DATA_W-1:0]  CLIP_LO = 16'h03FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              adc_ovr_pin,
    input  logic              out_en,
    input  logic              gain_wr,
    input  logic [GAIN_W-1:0] gain_wdata,
    input  logic              err_clr,
    output logic [GAIN_W-1:0] gain_code,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_offs,
    output logic [DATA_W-1:0] smp_tc,
    output logic              smp_ovr,
    output logic [CNT_W-1:0]  ovr_count,
    output logic              ovr_mismatch,
    output logic              illegal_gain
);
    localparam int MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    logic gain_chg;
    logic live_nxt;
    logic clip_now;

    adc_gain_ctrl #(.GAIN_W(GAIN_W)) u_gain (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (gain_wr),
        .wdata     (gain_wdata),
        .err_clr   (err_clr),
        .gain_code (gain_code),
        .illegal   (illegal_gain),
        .changed   (gain_chg)
    );

    adc_settle_fsm #(.BLANK(BLANK)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_en   (out_en),
        .gain_chg (gain_chg),
        .live_nxt (live_nxt)
    );

    always_comb begin
        clip_now = (adc_data >= CLIP_HI) || (adc_data <= CLIP_LO);
    end

    adc_ovr_stat #(.CNT_W(CNT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (live_nxt),
        .calc_ovr (clip_now),
        .pin_ovr  (adc_ovr_pin),
        .err_clr  (err_clr),
        .count    (ovr_count),
        .mismatch (ovr_mismatch)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_offs  <= MID;
            smp_tc    <= '0;
            smp_ovr   <= 1'b0;
        end else begin
            smp_valid <= live_nxt;
            smp_offs  <= adc_data;
            smp_tc    <= {~adc_data[MSB], adc_data[MSB-1:0]};
            smp_ovr   <= clip_now;
        end
    end
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
    parameter int                 DATA_W  = 16,
    parameter int                 GAIN_W  = 3,
    parameter int                 CNT_W   = 32,
    parameter logic [DATA_W-1:0]  CLIP_HI = 16'hFC00,
    parameter logic [DATA_W-1:0]  CLIP_LO = 16'h03FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_en,
    input logic              gain_wr,
    input logic [GAIN_W-1:0] gain_wdata,
    input logic              err_clr,
    input logic [GAIN_W-1:0] gain_code,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_offs,
    input logic [DATA_W-1:0] smp_tc,
    input logic              smp_ovr,
    input logic [CNT_W-1:0]  ovr_count,
    input logic              ovr_mismatch,
    input logic              illegal_gain
);
    localparam logic [GAIN_W-1:0] BAD = {GAIN_W{1'b1}};

    AST_TC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tc == {~smp_offs[DATA_W-1], smp_offs[DATA_W-2:0]}); // R3
    AST_CLIP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ovr == ((smp_offs >= CLIP_HI) || (smp_offs <= CLIP_LO))); // R4
    AST_VALID_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $past(out_en)); // R5
    AST_ENABLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |=> !smp_valid); // R5
    AST_GAIN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_code) |-> !smp_valid); // R6
    AST_GAIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        gain_code != BAD); // R7
    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_wr && gain_wdata == BAD) |=> $stable(gain_code)); // R7
    AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_gain && !err_clr) |=> illegal_gain); // R7
    AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_count >= $past(ovr_count)); // R8
    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_mismatch && !err_clr) |=> ovr_mismatch); // R9
endmodule

bind adc_capture adc_capture_chk #(
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W),
    .CNT_W  (CNT_W),
    .CLIP_HI(CLIP_HI),
    .CLIP_LO(CLIP_LO)
) u_chk (.*);

// File: tb/test_adc_capture.sv
module test_adc_capture;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [15:0]   adc_data;
    logic          adc_ovr_pin;
    logic          out_en;
    logic          gain_wr;
    logic [2:0]    gain_wdata;
    logic          err_clr;
    logic [2:0]    gain_code;
    logic          smp_valid;
    logic [15:0]   smp_offs;
    logic [15:0]   smp_tc;
    logic          smp_ovr;
    logic [CW-1:0] ovr_count;
    logic          ovr_mismatch;
    logic          illegal_gain;

    int checks = 0;
    int failures = 0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    adc_capture #(.CNT_W(CW)) i_adc_capture (
        .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .adc_ovr_pin(adc_ovr_pin),
        .out_en(out_en), .gain_wr(gain_wr), .gain_wdata(gain_wdata), .err_clr(err_clr),
        .gain_code(gain_code), .smp_valid(smp_valid), .smp_offs(smp_offs),
        .smp_tc(smp_tc), .smp_ovr(smp_ovr), .ovr_count(ovr_count),
        .ovr_mismatch(ovr_mismatch), .illegal_gain(illegal_gain)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one sample at a negedge, let one rising edge pass
    task automatic sample(input logic [15:0] d, input logic pin);
        adc_data    = d;
        adc_ovr_pin = pin;
        @(negedge clk);
    endtask

    // the first sampled edge already passed; expects 5 more invalid, then valid
    task automatic blank_window(input string tag);
        check({tag, " first blanked"}, 32'(smp_valid), 0);
        gain_wr = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (i == 4) begin
                adc_data = 16'h8000;
            end
            @(negedge clk);
            check(tag, 32'(smp_valid), 0);
        end
        @(negedge clk);
        check({tag, " valid after window"}, 32'(smp_valid), 1);
        check({tag, " blank ignored by counter R8"}, 32'(ovr_count), 32'(exp_cnt));
        check({tag, " blank ignored by mismatch R9"}, 32'(ovr_mismatch), 0);
    endtask

    task automatic t_reset();
        check("R1 valid", 32'(smp_valid), 0);
        check("R1 offs", 32'(smp_offs), 32'h8000);
        check("R1 tc", 32'(smp_tc), 0);
        check("R1 ovr", 32'(smp_ovr), 0);
        check("R1 gain", 32'(gain_code), 0);
        check("R1 count", 32'(ovr_count), 0);
        check("R1 flags", {30'b0, ovr_mismatch, illegal_gain}, 0);
    endtask

    task automatic t_enable();
        sample(16'h4000, 1'b0);
        check("R5 disabled", 32'(smp_valid), 0);
        adc_data    = 16'h0000;   // clipped, pin disagrees, but blanked
        adc_ovr_pin = 1'b0;
        out_en      = 1'b1;
        @(negedge clk);
        blank_window("R5 enable");
    endtask

    task automatic t_data();
        sample(16'h1234, 1'b0);
        check("R2 offs", 32'(smp_offs), 32'h1234);
        check("R3 tc", 32'(smp_tc), 32'h9234);
        check("R4 inside", 32'(smp_ovr), 0);
        sample(16'h8000, 1'b0);
        check("R3 midscale tc", 32'(smp_tc), 0);
        sample(16'hA5C3, 1'b0);
        check("R2 offs pattern", 32'(smp_offs), 32'hA5C3);
        check("R3 tc pattern", 32'(smp_tc), 32'h25C3);
    endtask

    task automatic t_clip();
        logic [15:0] v [6] = '{16'hFC00, 16'hFBFF, 16'h03FF, 16'h0400, 16'h0000, 16'hFFFF};
        logic        e [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
        for (int i = 0; i < 6; i++) begin
            sample(v[i], e[i]);
            check("R4 clip window", 32'(smp_ovr), 32'(e[i]));
            if (e[i]) exp_cnt++;
            check("R8 count", 32'(ovr_count), 32'(exp_cnt));
        end
        check("R9 no mismatch when agreeing", 32'(ovr_mismatch), 0);
    endtask

    task automatic t_mismatch();
        sample(16'h5000, 1'b1);
        check("R9 set", 32'(ovr_mismatch), 1);
        sample(16'h5000, 1'b0);
        check("R9 sticky", 32'(ovr_mismatch), 1);
        err_clr = 1'b1;
        sample(16'hFE00, 1'b0);   // set and clear together: set wins
        exp_cnt++;
        check("R9 set beats clear", 32'(ovr_mismatch), 1);
        sample(16'h5000, 1'b0);
        err_clr = 1'b0;
        check("R9 cleared", 32'(ovr_mismatch), 0);
        check("R8 count", 32'(ovr_count), 32'(exp_cnt));
    endtask

    task automatic t_gain();
        adc_data    = 16'h0000;
        adc_ovr_pin = 1'b0;
        gain_wr     = 1'b1;
        gain_wdata  = 3'b011;
        @(negedge clk);
        check("R6 gain applied", 32'(gain_code), 3);
        blank_window("R6 retune");
        gain_wr    = 1'b1;
        gain_wdata = 3'b011;
        sample(16'h8000, 1'b0);
        gain_wr = 1'b0;
        check("R6 same code keeps valid", 32'(smp_valid), 1);
    endtask

    task automatic t_illegal();
        gain_wr    = 1'b1;
        gain_wdata = 3'b111;
        sample(16'h8000, 1'b0);
        gain_wr = 1'b0;
        check("R7 gain kept", 32'(gain_code), 3);
        check("R7 flag set", 32'(illegal_gain), 1);
        check("R7 no blank", 32'(smp_valid), 1);
        sample(16'h8000, 1'b0);
        check("R7 sticky", 32'(illegal_gain), 1);
        err_clr = 1'b1;
        sample(16'h8000, 1'b0);
        err_clr = 1'b0;
        check("R7 cleared", 32'(illegal_gain), 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 16; i++) begin
            sample(16'hFFFF, 1'b1);
        end
        check("R8 saturated", 32'(ovr_count), 32'((1 << CW) - 1));
        sample(16'h0001, 1'b1);
        check("R8 holds at max", 32'(ovr_count), 32'((1 << CW) - 1));
    endtask

    task automatic t_disable();
        out_en = 1'b0;
        sample(16'h8000, 1'b0);
        check("R5 disable", 32'(smp_valid), 0);
        sample(16'h8000, 1'b0);
        check("R5 stays off", 32'(smp_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        adc_data    = 16'h0000;
        adc_ovr_pin = 1'b0;
        out_en      = 1'b0;
        gain_wr     = 1'b0;
        gain_wdata  = 3'b000;
        err_clr     = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_data();
        t_clip();
        t_mismatch();
        t_gain();
        t_illegal();
        t_saturate();
        t_disable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule